// File: doc/BRIEF.md
# Fifth-Order Sinc Decimator for a Multibit Modulator

This block is the first decimation stage of one audio record channel. Each time the modulator clock enable is high it takes the modulator's 31-line flash output, counts the active lines and turns that count into a signed 5-bit sample. The sample runs through five cascaded integrators at the full modulator rate. Five comb stages then run once per output sample, so the output has a fifth-order sinc response.

A rate-mode input sets the decimation ratio. The ratio is 16 when the following half-band chain runs at the lower sample rate and 8 at the doubled rate. Every datapath register wraps in 25-bit two's complement, which is the input width plus five times log2 of the largest ratio. Results are exact with no scaling. A one-cycle strobe marks each new output word for the half-band stages downstream. A change of rate mode clears the filter and starts it again from zero.

Top module: `sinc5_decimator`

## Requirements
- R1: Each accepted input word becomes the sample value (number of ones in `therm_in`) − 16. Only the count of set bits matters, not their positions, so the range is −16 (no bits set) to +15 (all 31 bits set).
- R2: Each output word equals the sum over j of h[j]·x[n−j]. Here x[n] is the sample accepted at the enable that completes the group, earlier samples back to the last clear are included, and samples before the clear count as zero. The taps h are the coefficients of (1 + z⁻¹ + … + z⁻⁽ᴺ⁻¹⁾)⁵, where N is the selected ratio.
- R3: `rate_sel` = 0 selects a ratio of 16 and `rate_sel` = 1 selects 8. An output is produced on every Nth clock cycle in which `ce` is high.
- R4: `out_valid` is high for exactly one cycle. That cycle immediately follows the clock edge that accepted the Nth sample.
- R5: `out_data` keeps its value in every cycle in which `out_valid` is low.
- R6: Arithmetic wraps at 25 bits and is exact at full scale. A steady all-zero input at ratio 16 settles to −2²⁴, and a steady all-ones input settles to 15·2²⁰.
- R7: When `rate_sel` differs from the mode in use, that cycle clears every integrator, comb delay and the sample counter, and any sample offered in that cycle is discarded. The first output in the new mode follows the Nth enabled sample after the change.
- R8: While `rst` is high at a clock edge, `out_valid` and `out_data` are driven to zero.
- R9: Input words offered in cycles with `ce` low have no effect on any later output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst | input | 1 | Synchronous reset, active high |
| ce | input | 1 | Modulator sample enable; one input word per high cycle |
| rate_sel | input | 1 | Decimation mode: 0 = divide by 16, 1 = divide by 8 |
| therm_in | input | 31 | Thermometer-coded flash output of the modulator |
| out_data | output | 25 | Decimated two's-complement sample |
| out_valid | output | 1 | One-cycle strobe marking a new `out_data` word |

## Verification
The bench drives full-scale runs of all zeros and all ones at ratio 16. A design that saturates, truncates or sizes its registers wrongly ends those runs at a value other than −2²⁴ or 15·2²⁰. It uses scattered bit patterns to catch a converter that reads the highest set bit instead of the count. It changes the mode while a sample is offered, which exposes designs that keep stale integrator state or count that sample toward the first new group. Idle stretches with noisy input words catch a design that accumulates while `ce` is low. Random traffic is compared against a tap-by-tap convolution, which shows any off-by-one in the comb delays or in the cycle where the group ends.

// File: rtl/sinc5_pkg.sv
package sinc5_pkg;

    localparam int THERM_W   = 31;
    localparam int SAMP_W    = 5;
    localparam int ORDER     = 5;
    localparam int HI_R_LOG2 = 4;
    localparam int LO_R_LOG2 = 3;

    localparam int ACC_W = SAMP_W + ORDER * HI_R_LOG2;
    localparam int HI_R  = 1 << HI_R_LOG2;
    localparam int LO_R  = 1 << LO_R_LOG2;

    typedef enum logic {
        RATE_DIV16 = 1'b0,
        RATE_DIV8  = 1'b1
    } rate_e;

    typedef logic [ACC_W-1:0] acc_t;

    typedef struct packed {
        logic vld;
        acc_t data;
    } dec_out_s;

    function automatic acc_t sext_samp(input logic [SAMP_W-1:0] s);
        return {{(ACC_W-SAMP_W){s[SAMP_W-1]}}, s};
    endfunction

endpackage

// File: rtl/sinc5_therm2bin.sv
module sinc5_therm2bin #(
    parameter int TW = sinc5_pkg::THERM_W,
    parameter int SW = sinc5_pkg::SAMP_W
) (
    input  logic [TW-1:0] therm_i,
    output logic [SW-1:0] samp_o
);
    localparam int CW = $clog2(TW + 1);

    logic [CW-1:0] ones;

    always_comb begin
        ones = '0;
        for (int i = 0; i < TW; i++) begin
            ones = ones + CW'(therm_i[i]);
        end
    end

    // count minus half scale, two's complement
    assign samp_o = SW'(ones) - SW'(1 << (SW - 1));

endmodule

// File: rtl/sinc5_integrators.sv
module sinc5_integrators #(
    parameter int ORD = sinc5_pkg::ORDER,
    parameter int W   = sinc5_pkg::ACC_W
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         clr,
    input  logic         en,
    input  logic [W-1:0] x_i,
    output logic [W-1:0] sum_nxt_o
);
    logic [ORD-1:0][W-1:0] acc_q;
    logic [ORD-1:0][W-1:0] acc_d;

    for (genvar g = 0; g < ORD; g++) begin : g_stage
        if (g == 0) begin : g_first
            assign acc_d[g] = acc_q[g] + x_i;
        end else begin : g_rest
            assign acc_d[g] = acc_q[g] + acc_d[g-1];
        end

        always_ff @(posedge clk) begin
            if (rst || clr) begin
                acc_q[g] <= '0;
            end else if (en) begin
                acc_q[g] <= acc_d[g];
            end
        end
    end

    assign sum_nxt_o = acc_d[ORD-1];

endmodule

// File: rtl/sinc5_combs.sv
module sinc5_combs #(
    parameter int ORD = sinc5_pkg::ORDER,
    parameter int W   = sinc5_pkg::ACC_W
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         clr,
    input  logic         dec,
    input  logic [W-1:0] x_i,
    output logic [W-1:0] y_o
);
    logic [ORD-1:0][W-1:0] dly_q;
    logic [ORD-1:0][W-1:0] stage_in;
    logic [ORD-1:0][W-1:0] diff;

    for (genvar g = 0; g < ORD; g++) begin : g_stage
        if (g == 0) begin : g_first
            assign stage_in[g] = x_i;
        end else begin : g_rest
            assign stage_in[g] = diff[g-1];
        end

        assign diff[g] = stage_in[g] - dly_q[g];

        always_ff @(posedge clk) begin
            if (rst || clr) begin
                dly_q[g] <= '0;
            end else if (dec) begin
                dly_q[g] <= stage_in[g];
            end
        end
    end

    assign y_o = diff[ORD-1];

endmodule

// File: rtl/sinc5_rate_ctrl.sv
module sinc5_rate_ctrl
    import sinc5_pkg::*;
#(
    parameter int HI_RATIO = sinc5_pkg::HI_R,
    parameter int LO_RATIO = sinc5_pkg::LO_R
) (
    input  logic clk,
    input  logic rst,
    input  logic rate_sel_i,
    input  logic ce_i,
    output logic clr_o,
    output logic dec_o
);
    localparam int CW = $clog2(HI_RATIO);

    rate_e         rate_q;
    logic [CW-1:0] phase_q;
    logic [CW-1:0] last_phase;

    assign clr_o      = (rate_e'(rate_sel_i) != rate_q);
    assign last_phase = (rate_q == RATE_DIV8) ? CW'(LO_RATIO - 1) : CW'(HI_RATIO - 1);
    assign dec_o      = ce_i && !clr_o && (phase_q == last_phase);

    always_ff @(posedge clk) begin
        if (rst || clr_o) begin
            rate_q  <= rate_e'(rate_sel_i);
            phase_q <= '0;
        end else if (ce_i) begin
            phase_q <= dec_o ? '0 : phase_q + 1'b1;
        end
    end

endmodule

// File: rtl/sinc5_decimator.sv
module sinc5_decimator
    import sinc5_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  logic               ce,
    input  logic               rate_sel,
    input  logic [THERM_W-1:0] therm_in,
    output logic [ACC_W-1:0]   out_data,
    output logic               out_valid
);
    logic [SAMP_W-1:0] samp;
    logic              clr;
    logic              dec;
    acc_t              integ_nxt;
    acc_t              comb_y;
    dec_out_s          out_q;

    sinc5_therm2bin #(.TW(THERM_W), .SW(SAMP_W)) i_conv (
        .therm_i (therm_in),
        .samp_o  (samp)
    );

    sinc5_rate_ctrl #(.HI_RATIO(HI_R), .LO_RATIO(LO_R)) i_ctrl (
        .clk        (clk),
        .rst        (rst),
        .rate_sel_i (rate_sel),
        .ce_i       (ce),
        .clr_o      (clr),
        .dec_o      (dec)
    );

    sinc5_integrators #(.ORD(ORDER), .W(ACC_W)) i_integ (
        .clk       (clk),
        .rst       (rst),
        .clr       (clr),
        .en        (ce && !clr),
        .x_i       (sext_samp(samp)),
        .sum_nxt_o (integ_nxt)
    );

    sinc5_combs #(.ORD(ORDER), .W(ACC_W)) i_comb (
        .clk (clk),
        .rst (rst),
        .clr (clr),
        .dec (dec),
        .x_i (integ_nxt),
        .y_o (comb_y)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            out_q <= '0;
        end else begin
            out_q.vld <= dec;
            if (dec) begin
                out_q.data <= comb_y;
            end
        end
    end

    assign out_data  = out_q.data;
    assign out_valid = out_q.vld;

endmodule

// File: rtl/sinc5_decimator_chk.sv
module sinc5_decimator_chk
    import sinc5_pkg::*;
(
    input logic             clk,
    input logic             rst,
    input logic             ce,
    input logic             rate_sel,
    input logic [ACC_W-1:0] out_data,
    input logic             out_valid
);
    localparam int SW = $clog2(HI_R) + 1;

    logic [SW-1:0] ce_seen;
    logic          mode_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            ce_seen <= '0;
            mode_q  <= rate_sel;
        end else if (rate_sel != mode_q) begin
            ce_seen <= '0;
            mode_q  <= rate_sel;
        end else if (out_valid) begin
            ce_seen <= ce ? SW'(1) : '0;
        end else if (ce) begin
            ce_seen <= ce_seen + 1'b1;
        end
    end

    // R3
    ratio_count_chk: assert property (@(posedge clk) disable iff (rst)
        out_valid |-> (ce_seen == (mode_q ? SW'(LO_R) : SW'(HI_R))));

    // R4
    strobe_width_chk: assert property (@(posedge clk) disable iff (rst)
        out_valid |=> !out_valid);

    // R4
    strobe_after_ce_chk: assert property (@(posedge clk) disable iff (rst)
        out_valid |-> $past(ce));

    // R5
    data_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !out_valid |-> $stable(out_data));

    // R7
    mode_clear_chk: assert property (@(posedge clk) disable iff (rst)
        (rate_sel != $past(rate_sel)) |=> !out_valid);

endmodule

bind sinc5_decimator sinc5_decimator_chk i_chk (
    .clk       (clk),
    .rst       (rst),
    .ce        (ce),
    .rate_sel  (rate_sel),
    .out_data  (out_data),
    .out_valid (out_valid)
);

// File: tb/test_sinc5_decimator.sv
`timescale 1ns/1ps
module test_sinc5_decimator;
    import sinc5_pkg::*;

    logic               clk = 1'b0;
    logic               rst = 1'b1;
    logic               ce = 1'b0;
    logic               rate_sel = 1'b0;
    logic [THERM_W-1:0] therm_in = '0;
    logic [ACC_W-1:0]   out_data;
    logic               out_valid;

    int checks = 0;
    int errors = 0;
    int h[0:79];
    int hist[0:79];
    int grp = 0;
    logic m_rate = 1'b0;
    logic m_valid = 1'b0;
    logic [ACC_W-1:0] m_data = '0;
    logic [ACC_W-1:0] last_seen = '0;
    string tag = "R2";

    sinc5_decimator i_sinc5_decimator (
        .clk       (clk),
        .rst       (rst),
        .ce        (ce),
        .rate_sel  (rate_sel),
        .therm_in  (therm_in),
        .out_data  (out_data),
        .out_valid (out_valid)
    );

    always #5 clk = ~clk;

    function automatic void build_taps(input int r);
        int tmp[0:79];
        int len;
        foreach (h[i]) h[i] = 0;
        h[0] = 1;
        len = 1;
        for (int s = 0; s < ORDER; s++) begin
            foreach (tmp[i]) tmp[i] = 0;
            for (int i = 0; i < len; i++)
                for (int k = 0; k < r; k++) tmp[i+k] += h[i];
            len += r - 1;
            h = tmp;
        end
    endfunction

    task automatic check(input bit ok, input string req, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
        end
    endtask

    task automatic step(input logic c, input logic [THERM_W-1:0] t, input logic rs);
        longint acc;
        ce = c;
        therm_in = t;
        rate_sel = rs;
        @(posedge clk);
        if (rs != m_rate) begin
            m_rate = rs;
            grp = 0;
            foreach (hist[i]) hist[i] = 0;
            build_taps(rs ? LO_R : HI_R);
            m_valid = 1'b0;
        end else if (c) begin
            for (int i = 79; i > 0; i--) hist[i] = hist[i-1];
            hist[0] = $countones(t) - 16;
            grp++;
            if (grp == (m_rate ? LO_R : HI_R)) begin
                acc = 0;
                for (int i = 0; i < 80; i++) acc += longint'(h[i]) * longint'(hist[i]);
                m_data = ACC_W'(acc);
                m_valid = 1'b1;
                grp = 0;
            end else begin
                m_valid = 1'b0;
            end
        end else begin
            m_valid = 1'b0;
        end
        @(negedge clk);
        check(out_valid === m_valid, "R3 R4", longint'(out_valid), longint'(m_valid));
        if (m_valid)
            check(out_data === m_data, tag, longint'($signed(out_data)), longint'($signed(m_data)));
        else
            check(out_data === m_data, "R5", longint'($signed(out_data)), longint'($signed(m_data)));
        if (out_valid) last_seen = out_data;
    endtask

    function automatic logic [THERM_W-1:0] rand_word();
        int k;
        k = $urandom_range(0, THERM_W);
        if ($urandom_range(0, 1) == 0)
            return THERM_W'((64'd1 << k) - 1);
        return THERM_W'($urandom());
    endfunction

    initial begin
        #2000000;
        errors++;
        checks++;
        $display("FAIL watchdog expired");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        int first;
        logic rs;
        void'($urandom(32'd4242));
        build_taps(HI_R);
        foreach (hist[i]) hist[i] = 0;

        repeat (4) @(posedge clk);
        @(negedge clk);
        // R8 reset values
        check(out_valid === 1'b0, "R8", longint'(out_valid), 0);
        check(out_data === '0, "R8", longint'($signed(out_data)), 0);
        rst = 1'b0;

        // R6 full scale at ratio 16
        tag = "R6";
        repeat (6 * HI_R) step(1'b1, '0, 1'b0);
        check(last_seen === ACC_W'(-(64'sd1 <<< 24)), "R6", longint'($signed(last_seen)), -(64'sd1 <<< 24));
        repeat (6 * HI_R) step(1'b1, '1, 1'b0);
        check(last_seen === ACC_W'(15 * (1 << 20)), "R6", longint'($signed(last_seen)), 15 * (1 << 20));

        // R7 mode change with a sample offered that cycle
        tag = "R7";
        step(1'b1, '1, 1'b1);
        first = 0;
        for (int k = 1; k <= 2 * LO_R; k++) begin
            step(1'b1, rand_word(), 1'b1);
            if (out_valid && first == 0) first = k;
        end
        check(first == LO_R, "R7", first, LO_R);

        // R1 scattered patterns at ratio 8, steady state = x * 8^5
        tag = "R1";
        for (int p = 0; p < 5; p++) begin
            logic [THERM_W-1:0] w;
            case (p)
                0: w = 31'h0000_0001;
                1: w = 31'h5555_5555;
                2: w = 31'h4000_0000;
                3: w = 31'h7FFF_FFFF;
                default: w = 31'h0F0F_00F0;
            endcase
            repeat (6 * LO_R) step(1'b1, w, 1'b1);
            check($signed(last_seen) == ($countones(w) - 16) * 32768, "R1",
                  longint'($signed(last_seen)), longint'(($countones(w) - 16) * 32768));
        end

        // R9 noisy input with enable low
        tag = "R9";
        repeat (40) step(1'b0, rand_word(), 1'b1);
        repeat (3 * LO_R) step(1'b1, rand_word(), 1'b1);

        // R2 random traffic, occasional mode flips
        tag = "R2";
        rs = 1'b1;
        for (int n = 0; n < 6000; n++) begin
            if ($urandom_range(0, 399) == 0) rs = ~rs;
            step($urandom_range(0, 3) != 0, rand_word(), rs);
        end

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule